// File: doc/BRIEF.md
# Sync Word Detector with Preamble Quality Qualifier

This block sits behind a demodulator and watches the hard-decided receive bitstream, one bit per cycle in which `bit_valid` is high. It estimates how preamble-like the recent traffic has been by counting bit transitions. At the same time it slides a window over the stream, looking for a programmable 16-bit synchronization pattern, or for that pattern sent twice in a row.

A match may be exact or may tolerate a few wrong bits, depending on the selected mode. A match becomes a one-cycle `sync_found` pulse only when every enabled qualifier holds. One qualifier is that the preamble quality must have reached its threshold since the search was armed. The other is that carrier sense must be high as the final sync bit arrives.

After a detection the block stops searching. It starts again after a one-cycle `rearm` pulse, which also discards all bits already collected. Downstream packet logic uses the pulse to mark where the payload begins.

Top module: `syncword_hunter`

## Requirements
- R1: During and right after synchronous reset, `sync_found`, `pq_reached` and `pq_count` are all 0.
- R2: For each valid bit that differs from the previous valid bit, `pq_count` rises by 1 and saturates at 31. The first valid bit after reset leaves the count unchanged, and so does any cycle without `bit_valid`.
- R3: For each valid bit that equals the previous valid bit, `pq_count` falls by 8 and saturates at 0.
- R4: When `pq_thr` is nonzero, `pq_reached` is high exactly when `pq_count` >= 4*`pq_thr`. When `pq_thr` is zero, `pq_reached` stays 0.
- R5: When `sync_mode[1:0]` is 00 (modes 0 and 4), `sync_found` never asserts.
- R6: In modes 2 and 6 (`sync_mode[1:0]`=10), the 16 most recent valid bits must equal `sync_word` exactly. The oldest of these bits is compared with `sync_word[15]`. `sync_found` is high for exactly the one cycle after the clock edge that takes the completing bit.
- R7: In modes 1 and 5 (`sync_mode[1:0]`=01), a 16-bit window with at most one mismatching bit is accepted. Two mismatches are rejected.
- R8: In modes 3 and 7 (`sync_mode[1:0]`=11), the 32 most recent bits are compared with {`sync_word`,`sync_word`}. Up to 2 mismatching bits are accepted, and 3 are rejected.
- R9: When `pq_thr` is nonzero, a match is accepted only if `pq_reached` has been high in some cycle since the search was armed, up to and including the cycle of the completing bit.
- R10: When `sync_mode[2]` is 1, a match is accepted only if `carrier_sense` is high in the cycle of the completing bit.
- R11: After `sync_found`, no further detection occurs until `rearm` is pulsed. After `rearm`, the full 16 or 32 pattern bits must arrive after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Qualifies `bit_in` this cycle |
| bit_in | input | 1 | Received hard-decision bit |
| sync_word | input | 16 | Synchronization pattern, first-sent bit in the MSB |
| sync_mode | input | 3 | Bit 2 selects the carrier-sense qualifier; bits 1:0 select off, 16-bit with one error, 16-bit exact, or 32-bit doubled |
| pq_thr | input | 3 | Preamble quality threshold in units of 4; zero disables the qualifier |
| carrier_sense | input | 1 | Carrier-sense flag from the signal-strength logic |
| rearm | input | 1 | One-cycle pulse that restarts the search |
| sync_found | output | 1 | One-cycle detection pulse |
| pq_reached | output | 1 | Preamble quality at or above the threshold |
| pq_count | output | 5 | Current preamble quality count |

## Verification
A corrupted quality counter shows up on `pq_count` one cycle after the next valid bit. From there it also reaches `pq_reached`, which changes in the same cycle as the count. A fault in the shift window, the bit fill count or the error tally shows up as a `sync_found` pulse that is missing, or that fires at a bit other than the final pattern bit. Each hunt in the bench is preceded by a transition-rich preamble, which makes an early or late pulse visible. A stuck armed or qualifier-latch state appears as a second detection without `rearm`, or as a detection without preamble. Such faults are caught within one sync-word time of the offending stimulus.

// File: rtl/syncdet_pkg.sv
package syncdet_pkg;

  typedef struct packed {
    logic enable;   // any search at all
    logic wide;     // doubled 32-bit pattern
    logic lenient;  // 16-bit with a single bit error allowed
    logic need_cs;  // carrier sense required at completion
  } sync_cfg_t;

  function automatic sync_cfg_t decode_mode(input logic [2:0] mode);
    sync_cfg_t c;
    c.enable  = (mode[1:0] != 2'b00);
    c.wide    = (mode[1:0] == 2'b11);
    c.lenient = (mode[1:0] == 2'b01);
    c.need_cs = mode[2];
    return c;
  endfunction

endpackage

// File: rtl/syncdet_quality.sv
module syncdet_quality #(
  parameter int CNT_W     = 5,
  parameter int THR_W     = 3,
  parameter int THR_SCALE = 4,
  parameter int STEP_UP   = 1,
  parameter int STEP_DN   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic [THR_W-1:0] pq_thr,
  output logic [CNT_W-1:0] count,
  output logic             reached
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic             prev_q;
  logic             have_prev_q;
  logic [CNT_W:0]   up_sum;
  logic [CNT_W-1:0] cnt_nxt;
  logic             reached_nxt;

  assign up_sum = {1'b0, count} + (CNT_W+1)'(STEP_UP);

  always_comb begin
    cnt_nxt = count;
    if (bit_valid && have_prev_q) begin
      if (bit_in != prev_q) begin
        cnt_nxt = (up_sum > (CNT_W+1)'(CNT_MAX)) ? CNT_W'(CNT_MAX) : up_sum[CNT_W-1:0];
      end else begin
        cnt_nxt = (count >= CNT_W'(STEP_DN)) ? (count - CNT_W'(STEP_DN)) : '0;
      end
    end
    reached_nxt = (pq_thr != '0) && (int'(cnt_nxt) >= int'(pq_thr) * THR_SCALE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count       <= '0;
      reached     <= 1'b0;
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
    end else begin
      count   <= cnt_nxt;
      reached <= reached_nxt;
      if (bit_valid) begin
        prev_q      <= bit_in;
        have_prev_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/syncdet_correlator.sv
module syncdet_correlator #(
  parameter int WORD_W = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bit_valid,
  input  logic                              bit_in,
  input  logic                              restart,
  input  logic                              wide,
  input  logic [WORD_W-1:0]                 sync_word,
  input  logic [$clog2(2*WORD_W+1)-1:0]     err_limit,
  output logic                              hit
);
  localparam int WIN_W = 2 * WORD_W;
  localparam int CW    = $clog2(WIN_W + 1);

  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] win_nxt;
  logic [WIN_W-1:0] ref_pat;
  logic [WIN_W-1:0] care;
  logic [WIN_W-1:0] diff;
  logic [CW-1:0]    fill_q;
  logic [CW-1:0]    errs;
  logic             enough;

  assign win_nxt = {win_q[WIN_W-2:0], bit_in};
  assign ref_pat = {sync_word, sync_word};

  // Lower half always takes part; upper half only for the doubled pattern.
  generate
    for (genvar i = 0; i < WIN_W; i++) begin : g_care
      if (i < WORD_W) begin : g_lo
        assign care[i] = 1'b1;
      end else begin : g_hi
        assign care[i] = wide;
      end
    end
  endgenerate

  assign diff = (win_nxt ^ ref_pat) & care;

  always_comb begin
    errs = '0;
    for (int i = 0; i < WIN_W; i++) begin
      errs = errs + CW'(diff[i]);
    end
  end

  assign enough = wide ? (fill_q >= CW'(WIN_W - 1)) : (fill_q >= CW'(WORD_W - 1));
  assign hit    = bit_valid && enough && (errs <= err_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      if (bit_valid) begin
        win_q <= win_nxt;
      end
      if (restart) begin
        fill_q <= '0;
      end else if (bit_valid && fill_q != CW'(WIN_W)) begin
        fill_q <= fill_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/syncword_hunter.sv
module syncword_hunter
  import syncdet_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int CNT_W      = 5,
  parameter int THR_W      = 3,
  parameter int THR_SCALE  = 4,
  parameter int STEP_UP    = 1,
  parameter int STEP_DN    = 8,
  parameter int NARROW_TOL = 1,
  parameter int WIDE_TOL   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic [WORD_W-1:0] sync_word,
  input  logic [2:0]        sync_mode,
  input  logic [THR_W-1:0]  pq_thr,
  input  logic              carrier_sense,
  input  logic              rearm,
  output logic              sync_found,
  output logic              pq_reached,
  output logic [CNT_W-1:0]  pq_count
);
  localparam int ERR_W = $clog2(2 * WORD_W + 1);

  sync_cfg_t        cfg;
  logic [ERR_W-1:0] err_limit;
  logic             hit;
  logic             armed_q;
  logic             pq_seen_q;
  logic             qual_ok;
  logic             cs_ok;
  logic             accept;

  assign cfg       = decode_mode(sync_mode);
  assign err_limit = cfg.wide    ? ERR_W'(WIDE_TOL)   :
                     cfg.lenient ? ERR_W'(NARROW_TOL) : '0;

  syncdet_quality #(
    .CNT_W(CNT_W), .THR_W(THR_W), .THR_SCALE(THR_SCALE),
    .STEP_UP(STEP_UP), .STEP_DN(STEP_DN)
  ) u_quality (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .pq_thr(pq_thr), .count(pq_count), .reached(pq_reached)
  );

  syncdet_correlator #(.WORD_W(WORD_W)) u_corr (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .restart(rearm), .wide(cfg.wide), .sync_word(sync_word),
    .err_limit(err_limit), .hit(hit)
  );

  // Qualifiers: latched preamble quality and live carrier sense.
  assign qual_ok = (pq_thr == '0) || pq_seen_q || pq_reached;
  assign cs_ok   = !cfg.need_cs || carrier_sense;
  assign accept  = armed_q && cfg.enable && hit && qual_ok && cs_ok && !rearm;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b1;
      pq_seen_q  <= 1'b0;
      sync_found <= 1'b0;
    end else begin
      sync_found <= accept;
      if (rearm) begin
        armed_q   <= 1'b1;
        pq_seen_q <= 1'b0;
      end else if (accept) begin
        armed_q   <= 1'b0;
        pq_seen_q <= 1'b0;
      end else begin
        pq_seen_q <= pq_seen_q | pq_reached;
      end
    end
  end

endmodule

// File: rtl/syncdet_checker.sv
module syncdet_checker #(
  parameter int CNT_W = 5,
  parameter int THR_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_valid,
  input logic             bit_in,
  input logic [2:0]       sync_mode,
  input logic [THR_W-1:0] pq_thr,
  input logic             carrier_sense,
  input logic             rearm,
  input logic             sync_found,
  input logic             pq_reached,
  input logic [CNT_W-1:0] pq_count
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic prev_q;
  logic have_prev_q;
  logic found_latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q        <= 1'b0;
      have_prev_q   <= 1'b0;
      found_latch_q <= 1'b0;
    end else begin
      if (bit_valid) begin
        prev_q      <= bit_in;
        have_prev_q <= 1'b1;
      end
      if (rearm) found_latch_q <= 1'b0;
      else if (sync_found) found_latch_q <= 1'b1;
    end
  end

  a_r2_rise: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && have_prev_q && bit_in != prev_q && pq_count != CNT_W'(CNT_MAX))
      |=> pq_count == $past(pq_count) + CNT_W'(1));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(pq_count));

  a_r3_fall: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && have_prev_q && bit_in == prev_q)
      |=> pq_count == (($past(pq_count) >= CNT_W'(8)) ? ($past(pq_count) - CNT_W'(8)) : '0));

  a_r4_off: assert property (@(posedge clk) disable iff (rst)
    pq_reached |-> $past(pq_thr) != '0);

  a_r5_disabled: assert property (@(posedge clk) disable iff (rst)
    sync_found |-> $past(sync_mode[1:0]) != 2'b00);

  a_r6_on_bit: assert property (@(posedge clk) disable iff (rst)
    sync_found |-> $past(bit_valid));

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sync_found |=> !sync_found);

  a_r10_carrier: assert property (@(posedge clk) disable iff (rst)
    sync_found |-> ($past(!sync_mode[2]) || $past(carrier_sense)));

  a_r11_no_repeat: assert property (@(posedge clk) disable iff (rst)
    sync_found |-> !found_latch_q);

endmodule

bind syncword_hunter syncdet_checker #(.CNT_W(CNT_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
  .sync_mode(sync_mode), .pq_thr(pq_thr), .carrier_sense(carrier_sense),
  .rearm(rearm), .sync_found(sync_found), .pq_reached(pq_reached),
  .pq_count(pq_count)
);

// File: tb/syncword_hunter_test.sv
`timescale 1ns/1ps
module syncword_hunter_test;
  localparam logic [15:0] SW = 16'h9A3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic [15:0] sync_word = SW;
  logic [2:0]  sync_mode = 3'd0;
  logic [2:0]  pq_thr = 3'd0;
  logic        carrier_sense = 1'b0;
  logic        rearm = 1'b0;
  logic        sync_found;
  logic        pq_reached;
  logic [4:0]  pq_count;

  int checks = 0;
  int failures = 0;
  int found_cnt = 0;
  logic last_found = 1'b0;
  int m_cnt = 0;
  logic m_prev = 1'b0;
  logic m_have = 1'b0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  syncword_hunter uut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .sync_word(sync_word), .sync_mode(sync_mode), .pq_thr(pq_thr),
    .carrier_sense(carrier_sense), .rearm(rearm), .sync_found(sync_found),
    .pq_reached(pq_reached), .pq_count(pq_count)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in = b;
    if (m_have) begin
      if (b != m_prev) m_cnt = (m_cnt == 31) ? 31 : m_cnt + 1;
      else m_cnt = (m_cnt >= 8) ? m_cnt - 8 : 0;
    end
    m_have = 1'b1;
    m_prev = b;
    @(negedge clk);
    bit_valid = 1'b0;
    last_found = sync_found;
    if (sync_found) found_cnt++;
  endtask

  task automatic send_preamble(input int n);
    for (int i = 0; i < n; i++) send_bit(m_have ? ~m_prev : 1'b0);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic do_rearm();
    @(negedge clk);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  task automatic hunt(input logic [31:0] v, input int n, input logic expect_hit, input string tag);
    do_rearm();
    send_preamble(32);
    found_cnt = 0;
    send_bits(v, n);
    check(found_cnt == int'(expect_hit), tag, found_cnt, int'(expect_hit));
    check(last_found == expect_hit, tag, int'(last_found), int'(expect_hit));
  endtask

  function automatic int exp_reached();
    return (pq_thr != 0 && m_cnt >= 4 * pq_thr) ? 1 : 0;
  endfunction

  task automatic t_reset();
    check(sync_found == 1'b0, "R1 sync_found", int'(sync_found), 0);
    check(pq_count == 5'd0, "R1 pq_count", pq_count, 0);
    check(pq_reached == 1'b0, "R1 pq_reached", int'(pq_reached), 0);
  endtask

  task automatic t_quality();
    sync_mode = 3'd0;
    pq_thr = 3'd0;
    send_bit(1'b1);
    check(pq_count == 0, "R2 first bit", pq_count, 0);
    send_preamble(5);
    check(pq_count == m_cnt && m_cnt == 5, "R2 rise", pq_count, m_cnt);
    repeat (3) @(negedge clk);
    check(pq_count == m_cnt, "R2 idle hold", pq_count, m_cnt);
    send_preamble(40);
    check(pq_count == 31, "R2 saturate", pq_count, 31);
    check(pq_reached == 1'b0, "R4 zero threshold", int'(pq_reached), 0);
    send_bit(m_prev);
    check(pq_count == 23, "R3 fall", pq_count, 23);
    repeat (3) send_bit(m_prev);
    check(pq_count == 0, "R3 floor", pq_count, 0);
  endtask

  task automatic t_threshold();
    pq_thr = 3'd3;
    send_preamble(11);
    check(int'(pq_reached) == exp_reached() && pq_reached == 1'b0, "R4 below", int'(pq_reached), 0);
    send_preamble(1);
    check(int'(pq_reached) == exp_reached() && pq_reached == 1'b1, "R4 reached", int'(pq_reached), 1);
    pq_thr = 3'd0;
  endtask

  task automatic t_disabled();
    carrier_sense = 1'b1;
    sync_mode = 3'd0;
    hunt({16'h0, SW}, 16, 1'b0, "R5 mode0");
    sync_mode = 3'd4;
    hunt({16'h0, SW}, 16, 1'b0, "R5 mode4");
    carrier_sense = 1'b0;
  endtask

  task automatic t_exact();
    sync_mode = 3'd2;
    hunt({16'h0, SW}, 16, 1'b1, "R6 exact match");
    hunt({16'h0, SW ^ 16'h0040}, 16, 1'b0, "R6 one error rejected");
  endtask

  task automatic t_lenient();
    sync_mode = 3'd1;
    hunt({16'h0, SW ^ 16'h0040}, 16, 1'b1, "R7 one error");
    hunt({16'h0, SW ^ 16'h0041}, 16, 1'b0, "R7 two errors");
  endtask

  task automatic t_wide();
    sync_mode = 3'd3;
    hunt({SW, SW} ^ 32'h0001_0100, 32, 1'b1, "R8 two errors");
    hunt({SW, SW} ^ 32'h8001_0100, 32, 1'b0, "R8 three errors");
  endtask

  task automatic t_carrier();
    sync_mode = 3'd6;
    carrier_sense = 1'b0;
    hunt({16'h0, SW}, 16, 1'b0, "R10 no carrier");
    carrier_sense = 1'b1;
    hunt({16'h0, SW}, 16, 1'b1, "R10 carrier");
    sync_mode = 3'd5;
    hunt({16'h0, SW ^ 16'h0200}, 16, 1'b1, "R10 mode5 carrier");
    carrier_sense = 1'b0;
  endtask

  task automatic t_qualifier();
    sync_mode = 3'd2;
    pq_thr = 3'd7;
    repeat (4) send_bit(m_prev);
    do_rearm();
    send_preamble(8);
    found_cnt = 0;
    send_bits({16'h0, SW}, 16);
    check(found_cnt == 0, "R9 short preamble", found_cnt, 0);
    send_preamble(32);
    found_cnt = 0;
    send_bits({16'h0, SW}, 16);
    check(found_cnt == 1 && last_found, "R9 long preamble", found_cnt, 1);
    pq_thr = 3'd0;
  endtask

  task automatic t_rearm();
    sync_mode = 3'd2;
    hunt({16'h0, SW}, 16, 1'b1, "R11 first find");
    send_preamble(32);
    found_cnt = 0;
    send_bits({16'h0, SW}, 16);
    check(found_cnt == 0, "R11 idle after find", found_cnt, 0);
    send_preamble(32);
    send_bits({24'h0, SW[15:8]}, 8);
    do_rearm();
    found_cnt = 0;
    send_bits({24'h0, SW[7:0]}, 8);
    check(found_cnt == 0, "R11 partial before rearm", found_cnt, 0);
    send_bits({16'h0, SW}, 16);
    check(found_cnt == 1 && last_found, "R11 full after rearm", found_cnt, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_quality();
    t_threshold();
    t_disabled();
    t_exact();
    t_lenient();
    t_wide();
    t_carrier();
    t_qualifier();
    t_rearm();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule